// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources into a pending vector. The vector follows the present level of each source and holds nothing. Two separate enable masks select which pending sources raise the normal request output and which raise the fast request output. Each request output is a registered OR-reduction of the pending vector ANDed with its mask.

Software reaches the block through a single-cycle register port that uses word indices. Reads are combinational and have no side effects. Each mask has one address that sets bits and a second address that clears bits, so one bit can be changed without a read-modify-write. A software-held flag is ORed into source 0, and a dedicated pair of set and clear addresses raises or lowers it. Software can therefore trigger an interrupt on that line whatever the hardware input is doing.

Top module: `lvl_intc`

## Requirements
- R1: The raw addresses (word index 1 for normal, 9 for fast) return the pending vector. The pending vector equals the present source inputs, with bit 0 also ORed with the software flag. It changes in the same cycle as the inputs.
- R2: `irq_o` goes high one clock edge after (pending AND normal mask) becomes nonzero, and goes low one edge after it becomes zero.
- R3: `fiq_o` behaves like `irq_o` but uses the fast mask.
- R4: Word index 0 reads pending AND normal mask. Word index 8 reads pending AND fast mask.
- R5: A write to index 2 (normal) or index 10 (fast) ORs the write data into that mask. Reading the same index returns the mask.
- R6: A write to index 3 (normal) or index 11 (fast) clears each mask bit whose data bit is 1. All other mask bits keep their value.
- R7: A write to index 4 with data bit 0 set raises the software flag. A write to index 5 with data bit 0 set lowers it. When data bit 0 is 0, either write leaves the flag unchanged, and data bits 31..1 are ignored. Index 4 reads the flag in bit 0, with all other bits zero.
- R8: The software flag affects only pending bit 0. Lowering the flag does not lower bit 0 while hardware source 0 is high.
- R9: Writes to the status and raw indices (0, 1, 8, 9) and to unmapped indices change no state. The clear indices (3, 5, 11) and unmapped indices read as zero.
- R10: After reset, both masks and the software flag are zero and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | 6 | Word index of the register accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The bench sweeps every source bit, enabling only that bit in one mask and then only in the other. This catches a design that crosses the two masks, that ignores the clear addresses, or that drops or shifts a bit lane. It checks that data bits above bit 0 written to the soft addresses do nothing. It also checks that lowering the flag while hardware source 0 is high leaves bit 0 pending, which a design that stored the flag in place of the level would get wrong. It samples the request outputs both before and after the edge that follows a source change. A combinational output would show the change too early, and an extra pipeline stage would show it too late. Writes to the read-only and unmapped indices must leave every register unchanged.

// File: rtl/lvl_intc.sv
module lvl_intc #(
  parameter int N_SRC = 32,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] addr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] rdata_o,
  output logic             irq_o,
  output logic             fiq_o
);

  localparam logic [IDX_W-1:0] IX_N_STAT = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_N_RAW  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_N_SET  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IX_N_CLR  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IX_SW_SET = IDX_W'(4);
  localparam logic [IDX_W-1:0] IX_SW_CLR = IDX_W'(5);
  localparam logic [IDX_W-1:0] IX_F_STAT = IDX_W'(8);
  localparam logic [IDX_W-1:0] IX_F_RAW  = IDX_W'(9);
  localparam logic [IDX_W-1:0] IX_F_SET  = IDX_W'(10);
  localparam logic [IDX_W-1:0] IX_F_CLR  = IDX_W'(11);

  logic [N_SRC-1:0] nmask_q, fmask_q, pend;
  logic             sw_q, irq_q, fiq_q;

  always_comb begin
    pend    = src_i;
    pend[0] = src_i[0] | sw_q;
  end

  wire wr_nset = wr_en_i && (addr_i == IX_N_SET);
  wire wr_nclr = wr_en_i && (addr_i == IX_N_CLR);
  wire wr_fset = wr_en_i && (addr_i == IX_F_SET);
  wire wr_fclr = wr_en_i && (addr_i == IX_F_CLR);
  wire wr_sset = wr_en_i && (addr_i == IX_SW_SET) && wdata_i[0];
  wire wr_sclr = wr_en_i && (addr_i == IX_SW_CLR) && wdata_i[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmask_q <= '0;
      fmask_q <= '0;
      sw_q    <= 1'b0;
    end else begin
      if (wr_nset) nmask_q <= nmask_q | wdata_i;
      if (wr_nclr) nmask_q <= nmask_q & ~wdata_i;
      if (wr_fset) fmask_q <= fmask_q | wdata_i;
      if (wr_fclr) fmask_q <= fmask_q & ~wdata_i;
      if (wr_sset) sw_q <= 1'b1;
      if (wr_sclr) sw_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |(pend & nmask_q);
      fiq_q <= |(pend & fmask_q);
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      IX_N_STAT: rdata_o = pend & nmask_q;
      IX_N_RAW:  rdata_o = pend;
      IX_N_SET:  rdata_o = nmask_q;
      IX_SW_SET: rdata_o[0] = sw_q;
      IX_F_STAT: rdata_o = pend & fmask_q;
      IX_F_RAW:  rdata_o = pend;
      IX_F_SET:  rdata_o = fmask_q;
      default:   rdata_o = '0;
    endcase
  end

  p_irq_masked_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (nmask_q == '0) |=> !irq_o);

  p_fiq_masked_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fmask_q == '0) |=> !fiq_o);

  p_irq_src_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_i & nmask_q) != '0) |=> irq_o);

  p_nset_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_nset |=> ((nmask_q & $past(wdata_i)) == $past(wdata_i)));

  p_fclr_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fclr |=> ((fmask_q & $past(wdata_i)) == '0));

  p_soft_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sset |=> (sw_q && rdata_o[0] == 1'b1 || addr_i != IX_N_RAW));

  p_clr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == IX_N_CLR || addr_i == IX_SW_CLR || addr_i == IX_F_CLR) |-> (rdata_o == '0));

  p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (addr_i == IX_N_STAT || addr_i == IX_F_RAW)) |=> ($stable(nmask_q) && $stable(fmask_q) && $stable(sw_q)));

  p_reset_quiet_r10: assert property (@(posedge clk)
    $fell(rst_n) |=> (!irq_o && !fiq_o));

endmodule

// File: tb/lvl_intc_tb_top.sv
module lvl_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_n = '0, m_f = '0, lf = 32'h1234_5679;
  logic        m_sw = 1'b0;

  always #10 clk = ~clk;

  lvl_intc dut_i (.clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en), .addr_i(addr),
                  .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq));

  function automatic logic [31:0] pend_m();
    return src | {31'b0, m_sw};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(int idx, logic [31:0] exp, string tag);
    addr = 6'(idx);
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 6'(idx); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    case (idx)
      2: m_n = m_n | d;
      3: m_n = m_n & ~d;
      4: if (d[0]) m_sw = 1'b1;
      5: if (d[0]) m_sw = 1'b0;
      10: m_f = m_f | d;
      11: m_f = m_f & ~d;
      default: ;
    endcase
  endtask

  task automatic chk_all(string tag);
    @(negedge clk);
    rd(0, pend_m() & m_n, {tag, " R4 nstat"});
    rd(1, pend_m(), {tag, " R1 nraw"});
    rd(2, m_n, {tag, " R5 nmask"});
    rd(3, '0, {tag, " R9 nclr"});
    rd(4, {31'b0, m_sw}, {tag, " R7 swflag"});
    rd(5, '0, {tag, " R9 swclr"});
    rd(8, pend_m() & m_f, {tag, " R4 fstat"});
    rd(9, pend_m(), {tag, " R1 fraw"});
    rd(10, m_f, {tag, " R5 fmask"});
    rd(11, '0, {tag, " R9 fclr"});
    rd(6, '0, {tag, " R9 unmapped"});
    chk({tag, " R2 irq"}, {31'b0, irq}, {31'b0, |(pend_m() & m_n)});
    chk({tag, " R3 fiq"}, {31'b0, fiq}, {31'b0, |(pend_m() & m_f)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_all("R10 reset");

    for (int b = 0; b < 32; b++) begin
      src = 32'h1 << b;
      wr(3, '1); wr(11, '1); wr(2, 32'h1 << b);
      chk_all("R2 lane");
      wr(10, 32'h1 << b); wr(3, 32'h1 << b);
      chk_all("R3 lane");
      wr(2, ~(32'h1 << b));
      chk_all("R6 others");
      src = '0;
      chk_all("R1 drop");
    end

    for (int i = 0; i < 40; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      src = lf & {lf[15:0], lf[31:16]};
      wr(2 + (i % 2) * 8, lf ^ 32'h0F0F_3C3C);
      wr(3 + ((i / 2) % 2) * 8, {lf[7:0], lf[31:8]});
      chk_all("R5 R6 mix");
    end

    src = '0; wr(3, '1); wr(11, '1); wr(2, 32'h1);
    wr(4, 32'hFFFF_FFFE);
    chk_all("R7 no bit0");
    wr(4, 32'h1);
    chk_all("R7 sw up");
    src[0] = 1'b1; wr(5, 32'hFFFF_FFFF);
    chk_all("R8 hw holds");
    src[0] = 1'b0;
    chk_all("R8 low");
    wr(4, 32'h1); wr(5, 32'h0);
    chk_all("R7 clr no bit0");
    wr(5, 32'h1);

    wr(10, 32'h0000_00F0);
    wr(0, '1); wr(1, '1); wr(8, '1); wr(9, '1); wr(6, '1); wr(31, '1);
    chk_all("R9 ro writes");

    @(negedge clk);
    src = 32'h0000_0010;
    #1;
    chk("R3 not early", {31'b0, fiq}, 32'h0);
    @(negedge clk);
    chk("R3 after edge", {31'b0, fiq}, 32'h1);

    rst_n = 1'b0;
    m_n = '0; m_f = '0; m_sw = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    src = '0;
    chk_all("R10 rereset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule